// File: doc/BRIEF.md
# PC-Relative Conditional Branch Unit

This block owns the program counter of a processor whose instructions are 16-bit words. In every cycle where an instruction is presented as valid, the block classifies it. It then either steps the PC to the next halfword, or tests a short-form conditional branch against five stored comparison flags and jumps, or raises a sticky illegal-instruction exception. A short branch carries a 4-bit condition selector and a signed 10-bit displacement counted in halfwords. The jump target is the branch's own address plus twice the displacement.

Ten conditions, signed and unsigned, are built from the five flags. The remaining six selector codes are illegal. An older branch encoding, which carried a 32-bit absolute target word after the opcode, is no longer supported and must trap. Once the exception is raised, the PC freezes and valid instructions are ignored until reset or an explicit clear. For checking against a reference model, the block reports a one-cycle taken strobe and the last computed branch target.

Top module: `pcrel_branch_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets pc_o to RESET_VEC (default 0x1000) and clears illegal_o, taken_o and target_o.
- R2: A valid instruction that is neither a short branch nor a legacy branch advances pc_o by 2 at the next edge, with taken_o low. This covers bit 15 clear outside the legacy range, and bit 15 set with bit 14 clear.
- R3: An instruction with bits 15 and 14 both set is a short branch. Bits 13:10 are the selector and bits 9:0 are a two's-complement halfword displacement. When the branch is taken, pc_o becomes the branch's own address plus 2 × displacement, modulo 2^PC_W.
- R4: flags_i is laid out as bit0 EQ, bit1 LT, bit2 GT, bit3 LTU, bit4 GTU. Each selector tests the following:
  - 0: EQ
  - 1: not EQ
  - 2: LT
  - 3: GT
  - 4: LTU
  - 5: GTU
  - 6: GT or EQ
  - 7: LT or EQ
  - 8: GTU or EQ
  - 9: LTU or EQ
- R5: A short branch whose condition is false advances pc_o by 2, with taken_o low.
- R6: A short branch with selector 10 to 15 sets illegal_o at the next edge and leaves pc_o unchanged.
- R7: With bit 15 clear, an instruction whose bits 15:8 lie in 0x0F to 0x18 inclusive sets illegal_o and leaves pc_o unchanged. The values 0x0E and 0x19 step normally.
- R8: When instr_valid is low, pc_o does not change and taken_o is low at the next edge.
- R9: While illegal_o is high, valid instructions are ignored and pc_o holds. When exc_clear is high at an edge, illegal_o is low afterwards and the instruction of that cycle is ignored. Execution then resumes from the held pc_o.
- R10: taken_o is high for exactly the cycle after a taken branch is accepted. target_o holds the target of the most recent taken branch until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction on instr is to be executed this cycle |
| instr | input | 16 | Instruction word |
| flags_i | input | 5 | Comparison flags: EQ, LT, GT, LTU, GTU in bits 0 to 4 |
| exc_clear | input | 1 | Clears the illegal-instruction exception |
| pc_o | output | PC_W | Current program counter |
| illegal_o | output | 1 | Sticky illegal-instruction exception |
| taken_o | output | 1 | One-cycle strobe after a taken branch |
| target_o | output | PC_W | Target of the most recent taken branch |

## Verification
The assertions assume that rst_n is low from time zero until at least one clock edge has passed, so that no register starts from an unknown value. They also assume that instr, flags_i, instr_valid and exc_clear are settled at every rising edge. The bench keeps to this by holding reset for several cycles. It changes every input only on falling edges and drops instr_valid and exc_clear shortly after each rising edge, so that each request is taken exactly once. The bench never raises exc_clear together with an instruction it expects to run, because the clear cycle discards that instruction.

// File: rtl/brcu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the PC-relative branch unit.
// Assumes 16-bit instruction words with the form bits in the top two bits.
package brcu_pkg;
    localparam int FLAG_N   = 5;
    localparam int FLAG_EQ  = 0;
    localparam int FLAG_LT  = 1;
    localparam int FLAG_GT  = 2;
    localparam int FLAG_LTU = 3;
    localparam int FLAG_GTU = 4;

    // Selectors at or above this value are illegal.
    localparam int SEL_LIMIT = 10;

    // Retired long-form branch opcodes (upper byte, bit 15 clear).
    localparam logic [7:0] LEGACY_LO = 8'h0F;
    localparam logic [7:0] LEGACY_HI = 8'h18;

    typedef enum logic [1:0] {
        K_STEP    = 2'd0,
        K_BRANCH  = 2'd1,
        K_ILLEGAL = 2'd2
    } kind_t;
endpackage

// File: rtl/brcu_classify.sv
`timescale 1ns/1ps
// Module: brcu_classify
// Splits an instruction word into its kind (plain step, short branch,
// illegal) and extracts the selector and displacement fields.
// Assumes IW >= SEL_W + DISP_W + 2 and IW >= 8.
module brcu_classify
    import brcu_pkg::*;
#(
    parameter int IW     = 16,
    parameter int SEL_W  = 4,
    parameter int DISP_W = 10
) (
    input  logic [IW-1:0]     instr,
    output kind_t             kind_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DISP_W-1:0] disp_o
);
    localparam int SEL_LSB = DISP_W;
    localparam int FORM_HI = IW - 1;
    localparam int FORM_LO = IW - 2;

    logic [7:0] opc_byte;
    logic       is_short;
    logic       is_legacy;

    // Field extraction: fixed bit slices of the instruction.
    assign sel_o    = instr[SEL_LSB +: SEL_W];
    assign disp_o   = instr[DISP_W-1:0];
    assign opc_byte = instr[IW-1 -: 8];

    // Form detection for the short branch and the retired long branch.
    always_comb begin
        is_short  = instr[FORM_HI] & instr[FORM_LO];
        is_legacy = !instr[FORM_HI] && (opc_byte >= LEGACY_LO) && (opc_byte <= LEGACY_HI);
    end

    // Kind selection: illegal selectors and legacy opcodes trap.
    always_comb begin
        if (is_short) begin
            kind_o = (int'(sel_o) >= SEL_LIMIT) ? K_ILLEGAL : K_BRANCH;
        end else if (is_legacy) begin
            kind_o = K_ILLEGAL;
        end else begin
            kind_o = K_STEP;
        end
    end
endmodule

// File: rtl/brcu_cond.sv
`timescale 1ns/1ps
// Module: brcu_cond
// Evaluates a condition selector against the five comparison flags.
// Assumes the caller has already screened out illegal selectors;
// those evaluate false here.
module brcu_cond
    import brcu_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic              hit_o
);
    logic eq, lt, gt, ltu, gtu;

    // Flag unpacking by fixed bit position.
    always_comb begin
        eq  = flags_i[FLAG_EQ];
        lt  = flags_i[FLAG_LT];
        gt  = flags_i[FLAG_GT];
        ltu = flags_i[FLAG_LTU];
        gtu = flags_i[FLAG_GTU];
    end

    // Condition table: signed and unsigned relations built from the flags.
    always_comb begin
        case (int'(sel_i))
            0:       hit_o = eq;
            1:       hit_o = !eq;
            2:       hit_o = lt;
            3:       hit_o = gt;
            4:       hit_o = ltu;
            5:       hit_o = gtu;
            6:       hit_o = gt | eq;
            7:       hit_o = lt | eq;
            8:       hit_o = gtu | eq;
            9:       hit_o = ltu | eq;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brcu_target.sv
`timescale 1ns/1ps
// Module: brcu_target
// Computes the sequential PC (PC + 2) and the branch target
// (PC + sign-extended displacement * 2). Arithmetic wraps modulo 2^PC_W.
// Assumes PC_W > DISP_W + 1.
module brcu_target #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 10
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   seq_o,
    output logic [PC_W-1:0]   tgt_o
);
    localparam int EXT_W = PC_W - DISP_W - 1;

    logic [PC_W-1:0] offset;

    // Byte offset: sign-extend the halfword count and shift left by one.
    always_comb begin
        offset = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 1'b0};
    end

    // Adders for the fall-through and taken paths.
    always_comb begin
        seq_o = pc_i + PC_W'(2);
        tgt_o = pc_i + offset;
    end
endmodule

// File: rtl/pcrel_branch_unit.sv
`timescale 1ns/1ps
// Module: pcrel_branch_unit
// Holds the program counter and executes short-form PC-relative
// conditional branches. Retired long-form branches and reserved selectors
// raise a sticky exception that freezes the PC until reset or exc_clear.
// Assumes one instruction per valid cycle and no pipelining.
module pcrel_branch_unit
    import brcu_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [4:0]        flags_i,
    input  logic              exc_clear,
    output logic [PC_W-1:0]   pc_o,
    output logic              illegal_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o
);
    localparam int IW     = 16;
    localparam int SEL_W  = 4;
    localparam int DISP_W = 10;

    kind_t             kind;
    logic [SEL_W-1:0]  sel;
    logic [DISP_W-1:0] disp;
    logic              hit;
    logic [PC_W-1:0]   seq_pc;
    logic [PC_W-1:0]   tgt_pc;
    logic              accept;
    logic              do_jump;

    brcu_classify #(.IW(IW), .SEL_W(SEL_W), .DISP_W(DISP_W)) u_cls (
        .instr  (instr),
        .kind_o (kind),
        .sel_o  (sel),
        .disp_o (disp)
    );

    brcu_cond #(.SEL_W(SEL_W)) u_cond (
        .sel_i   (sel),
        .flags_i (flags_i),
        .hit_o   (hit)
    );

    brcu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
        .pc_i   (pc_o),
        .disp_i (disp),
        .seq_o  (seq_pc),
        .tgt_o  (tgt_pc)
    );

    // Acceptance: a valid instruction runs only outside exception and clear cycles.
    always_comb begin
        accept  = instr_valid && !illegal_o && !exc_clear;
        do_jump = accept && (kind == K_BRANCH) && hit;
    end

    // PC register: step, jump, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= RESET_VEC;
        end else if (accept) begin
            case (kind)
                K_STEP:   pc_o <= seq_pc;
                K_BRANCH: pc_o <= hit ? tgt_pc : seq_pc;
                default:  pc_o <= pc_o;
            endcase
        end
    end

    // Exception flag: set on a trapping instruction, cleared by exc_clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
        end else if (exc_clear) begin
            illegal_o <= 1'b0;
        end else if (accept && (kind == K_ILLEGAL)) begin
            illegal_o <= 1'b1;
        end
    end

    // Taken strobe and last-target capture for observation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o  <= 1'b0;
            target_o <= '0;
        end else begin
            taken_o <= do_jump;
            if (do_jump) begin
                target_o <= tgt_pc;
            end
        end
    end
endmodule

// File: rtl/brcu_checker.sv
`timescale 1ns/1ps
// Module: brcu_checker
// Temporal properties of the branch unit, observed at its ports.
// Assumes synchronous active-low reset held from time zero.
module brcu_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [15:0]     instr,
    input logic            exc_clear,
    input logic [PC_W-1:0] pc_o,
    input logic            illegal_o,
    input logic            taken_o,
    input logic [PC_W-1:0] target_o
);
    logic plain_step;

    // Plain-step predicate from the instruction fields (bit 15 clear, not legacy).
    always_comb begin
        plain_step = instr_valid && !illegal_o && !exc_clear && !instr[15]
                     && ((instr[15:8] < 8'h0F) || (instr[15:8] > 8'h18));
    end

    p_step_adds_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        plain_step |=> (pc_o == $past(pc_o) + PC_W'(2)) && !taken_o);

    p_raise_holds_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_o) |-> pc_o == $past(pc_o));

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc_o) && !taken_o);

    p_exc_freezes_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable(pc_o));

    p_exc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !exc_clear) |=> illegal_o);

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_clear |=> !illegal_o);

    p_taken_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> pc_o == target_o);

    p_taken_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !instr_valid) |=> !taken_o);
endmodule

bind pcrel_branch_unit brcu_checker #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .exc_clear   (exc_clear),
    .pc_o        (pc_o),
    .illegal_o   (illegal_o),
    .taken_o     (taken_o),
    .target_o    (target_o)
);

// File: tb/sim_pcrel_branch_unit.sv
`timescale 1ns/1ps
// Directed bench for pcrel_branch_unit: one task per scenario.
module sim_pcrel_branch_unit;
    localparam int          PC_W = 32;
    localparam logic [31:0] RVEC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [4:0]  flags_i = '0;
    logic        exc_clear = 1'b0;
    logic [31:0] pc_o;
    logic        illegal_o;
    logic        taken_o;
    logic [31:0] target_o;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    pcrel_branch_unit #(.PC_W(PC_W), .RESET_VEC(RVEC)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .flags_i(flags_i), .exc_clear(exc_clear), .pc_o(pc_o),
        .illegal_o(illegal_o), .taken_o(taken_o), .target_o(target_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference condition table from the requirement text.
    function automatic bit ref_hit(input int s, input logic [4:0] f);
        bit eq = f[0], lt = f[1], gt = f[2], ltu = f[3], gtu = f[4];
        case (s)
            0: return eq;
            1: return !eq;
            2: return lt;
            3: return gt;
            4: return ltu;
            5: return gtu;
            6: return gt || eq;
            7: return lt || eq;
            8: return gtu || eq;
            9: return ltu || eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] byte_off(input logic [9:0] d);
        return {{21{d[9]}}, d, 1'b0};
    endfunction

    function automatic logic [15:0] mk_br(input int s, input logic [9:0] d);
        return {2'b11, 4'(s), d};
    endfunction

    // One request: driven at a falling edge, taken at the next rising edge, then retired.
    task automatic issue(input logic [15:0] w, input logic [4:0] f, input bit v, input bit clr);
        @(negedge clk);
        instr = w; flags_i = f; instr_valid = v; exc_clear = clr;
        @(posedge clk);
        #2;
        instr_valid = 1'b0; exc_clear = 1'b0;
    endtask

    task automatic t_reset;
        chk(pc_o == RVEC, "R1 pc", pc_o, RVEC);
        chk(!illegal_o && !taken_o, "R1 flags", {30'd0, illegal_o, taken_o}, 32'd0);
        chk(target_o == 32'd0, "R1 target", target_o, 32'd0);
        exp_pc = RVEC;
    endtask

    task automatic t_plain_steps;
        logic [15:0] words [4] = '{16'h0000, 16'h0E55, 16'h19AA, 16'h8123};
        for (int i = 0; i < 4; i++) begin
            issue(words[i], 5'h1F, 1'b1, 1'b0);
            exp_pc = exp_pc + 32'd2;
            chk(pc_o == exp_pc && !taken_o && !illegal_o, "R2 step", pc_o, exp_pc);
        end
    endtask

    task automatic t_all_conditions;
        for (int s = 0; s < 10; s++) begin
            for (int f = 0; f < 32; f++) begin
                logic [9:0] d = 10'((s * 37 + f * 11) % 1024);
                bit h = ref_hit(s, 5'(f));
                logic [31:0] e = h ? exp_pc + byte_off(d) : exp_pc + 32'd2;
                issue(mk_br(s, d), 5'(f), 1'b1, 1'b0);
                exp_pc = e;
                if (h) chk(pc_o == e && taken_o, "R4 R3 taken", pc_o, e);
                else   chk(pc_o == e && !taken_o, "R4 R5 not taken", pc_o, e);
            end
        end
    endtask

    task automatic t_disp_edges;
        logic [9:0] ds [4] = '{10'h1FF, 10'h200, 10'h000, 10'h3FF};
        for (int i = 0; i < 4; i++) begin
            logic [31:0] e = exp_pc + byte_off(ds[i]);
            issue(mk_br(0, ds[i]), 5'h01, 1'b1, 1'b0);
            exp_pc = e;
            chk(pc_o == e && taken_o && target_o == e, "R3 displacement edge", pc_o, e);
        end
    endtask

    task automatic t_strobe;
        logic [31:0] e = exp_pc + byte_off(10'h010);
        issue(mk_br(1, 10'h010), 5'h00, 1'b1, 1'b0);
        exp_pc = e;
        chk(taken_o == 1'b1, "R10 strobe high", {31'd0, taken_o}, 32'd1);
        issue(16'h0000, 5'h00, 1'b1, 1'b0);
        exp_pc = exp_pc + 32'd2;
        chk(taken_o == 1'b0, "R10 strobe one cycle", {31'd0, taken_o}, 32'd0);
        chk(target_o == e, "R10 target held", target_o, e);
    endtask

    task automatic t_idle;
        issue(mk_br(0, 10'h040), 5'h1F, 1'b0, 1'b0);
        chk(pc_o == exp_pc && !taken_o, "R8 idle", pc_o, exp_pc);
    endtask

    task automatic t_bad_selectors;
        for (int s = 10; s < 16; s++) begin
            issue(mk_br(s, 10'h020), 5'h1F, 1'b1, 1'b0);
            chk(illegal_o && pc_o == exp_pc && !taken_o, "R6 illegal selector", pc_o, exp_pc);
            issue(16'h0000, 5'h00, 1'b1, 1'b0);
            chk(illegal_o && pc_o == exp_pc, "R9 ignored while trapped", pc_o, exp_pc);
            issue(16'h0000, 5'h00, 1'b1, 1'b1);
            chk(!illegal_o && pc_o == exp_pc, "R9 clear", {31'd0, illegal_o}, 32'd0);
            issue(16'h0000, 5'h00, 1'b1, 1'b0);
            exp_pc = exp_pc + 32'd2;
            chk(pc_o == exp_pc, "R9 resume", pc_o, exp_pc);
        end
    endtask

    task automatic t_legacy;
        logic [7:0] ops [3] = '{8'h0F, 8'h13, 8'h18};
        for (int i = 0; i < 3; i++) begin
            issue({ops[i], 8'h00}, 5'h1F, 1'b1, 1'b0);
            chk(illegal_o && pc_o == exp_pc, "R7 legacy opcode", pc_o, exp_pc);
            issue(16'h0000, 5'h00, 1'b0, 1'b1);
            chk(!illegal_o, "R9 clear after legacy", {31'd0, illegal_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_plain_steps();
        t_all_conditions();
        t_disp_edges();
        t_strobe();
        t_idle();
        t_bad_selectors();
        t_legacy();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule